// File: doc/BRIEF.md
# Interrupt and Break Entry Sequencer

This block runs the multi-cycle stack and vector sequences that move a byte-wide processor core into and out of exception handlers. Four sequences exist. A software break and a maskable request each push a return address and a status byte onto a fixed 256-byte stack page and then load a new program counter from the vector pair at 0xFFFE/0xFFFF. A non-maskable request does the same but loads from the vector pair at 0xFFFA/0xFFFB. The return sequence pulls the status byte and the return address back off the stack.

The core presents its current program counter, stack pointer and status on the context inputs. It pulses a strobe when it decodes a break or a return, and it holds the two request lines. While a sequence runs, the block owns the memory port and raises `busy`. When `done` pulses, the core takes the new program counter, stack pointer and status from the result outputs. Memory reads are combinational: the byte for the address driven in a cycle is returned on `mem_rdata` in that same cycle.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `busy`, `done`, `mem_we` and `mem_re` are low, and `new_pc`, `new_sp` and `new_st` are zero.
- R2: An entry sequence writes three bytes to page 0x01: the PC high byte at SP, the PC low byte at SP-1 and the status at SP-2. Stack addresses wrap within the page. Afterwards `new_sp` is SP-3 (modulo 256).
- R3: A break pushes `cur_pc`+2 and the status with bit 4 set. A maskable or non-maskable entry pushes `cur_pc` unchanged and the status with bit 4 cleared. All other status bits are pushed as given.
- R4: After an entry, `new_st` equals the pushed status byte with bit 2 (the interrupt mask) set.
- R5: A break or maskable entry reads 0xFFFE and then 0xFFFF. A non-maskable entry reads 0xFFFA and then 0xFFFB. `new_pc` is {second byte, first byte}.
- R6: A sequence is accepted at a clock edge. `busy` is high for exactly 7 cycles after that edge for an entry and 6 for a return. `done` is high for the single cycle after `busy` falls, and the result outputs are valid from that cycle on. The pushes occupy busy cycles 3 to 5 and the vector reads cycles 6 and 7. The pulls occupy return cycles 4 to 6.
- R7: A maskable request is accepted only while idle, with `irq_req` high and `cur_st` bit 2 clear. When the mask bit is set, the memory port stays idle.
- R8: A rising edge of `nmi_req` is remembered, also while a sequence runs, and causes exactly one non-maskable entry. That entry starts at the first idle edge, which is the edge that ends the `done` cycle. A level held high does not trigger again.
- R9: In an idle cycle the priority is break strobe, then return strobe, then pending non-maskable request, then maskable request. Strobes that arrive while `busy` is high are ignored.
- R10: A return reads SP+1, SP+2 and SP+3 (modulo 256) as status, PC low and PC high. `new_st` is the pulled status with bit 5 forced to 1, `new_pc` is exactly the pulled address, and `new_sp` is SP+3.
- R11: `mem_re` and `mem_we` are never high together and are high only while `busy` is high. Read data is taken in the same cycle as its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_go | input | 1 | Break strobe from the core |
| rti_go | input | 1 | Return-from-interrupt strobe from the core |
| irq_req | input | 1 | Maskable request, level |
| nmi_req | input | 1 | Non-maskable request, rising edge counts |
| cur_pc | input | 16 | Program counter at acceptance |
| cur_sp | input | 8 | Stack pointer at acceptance |
| cur_st | input | 8 | Status at acceptance |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, same cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 16 | Resulting program counter |
| new_sp | output | 8 | Resulting stack pointer |
| new_st | output | 8 | Resulting status |

## Verification
The assertions assume that the context inputs are stable across every accepting edge. They also assume that the 0x01 stack page never overlaps the vector page, so that a push and the next one are always adjacent on the same page. The bench changes inputs only one time unit after a rising edge and leaves the context constant through each chained sequence. It clears the maskable request, or sets the mask bit, before an entry could be taken again. A behavioural memory serves the stack page and the four vector bytes combinationally, which matches the same-cycle read that the checker relies on.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int FLAG_I = 2;
    localparam int FLAG_B = 4;
    localparam int FLAG_R = 5;
    localparam logic [7:0] MASK_I = 8'(1 << FLAG_I);
    localparam logic [7:0] MASK_B = 8'(1 << FLAG_B);
    localparam logic [7:0] MASK_R = 8'(1 << FLAG_R);

    localparam int ENTRY_STEPS  = 7;
    localparam int RETURN_STEPS = 6;
    localparam int STEP_W       = $clog2(ENTRY_STEPS);
    localparam int ENTRY_PUSH0  = ENTRY_STEPS - 5;
    localparam int RETURN_PULL0 = RETURN_STEPS - 3;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_BRK,
        SRC_RTI,
        SRC_NMI,
        SRC_IRQ
    } src_e;

    typedef enum logic [3:0] {
        OP_WAIT,
        OP_PUSH_HI,
        OP_PUSH_LO,
        OP_PUSH_ST,
        OP_VEC_LO,
        OP_VEC_HI,
        OP_PULL_ST,
        OP_PULL_LO,
        OP_PULL_HI
    } op_e;

    typedef struct packed {
        logic [15:0] pc;
        logic [7:0]  sp;
        logic [7:0]  st;
    } ctx_t;

    function automatic op_e step_op(src_e s, logic [STEP_W-1:0] i);
        int k;
        k = int'(i);
        if (s == SRC_NONE) begin
            return OP_WAIT;
        end else if (s == SRC_RTI) begin
            if (k == RETURN_PULL0)     return OP_PULL_ST;
            if (k == RETURN_PULL0 + 1) return OP_PULL_LO;
            if (k == RETURN_PULL0 + 2) return OP_PULL_HI;
            return OP_WAIT;
        end else begin
            if (k == ENTRY_PUSH0)     return OP_PUSH_HI;
            if (k == ENTRY_PUSH0 + 1) return OP_PUSH_LO;
            if (k == ENTRY_PUSH0 + 2) return OP_PUSH_ST;
            if (k == ENTRY_PUSH0 + 3) return OP_VEC_LO;
            if (k == ENTRY_PUSH0 + 4) return OP_VEC_HI;
            return OP_WAIT;
        end
    endfunction

    function automatic logic [STEP_W-1:0] last_step(src_e s);
        return (s == SRC_RTI) ? STEP_W'(RETURN_STEPS - 1) : STEP_W'(ENTRY_STEPS - 1);
    endfunction

    function automatic logic [7:0] entry_status(src_e s, logic [7:0] st);
        case (s)
            SRC_BRK:          return st | MASK_B;
            SRC_IRQ, SRC_NMI: return st & ~MASK_B;
            default:          return st;
        endcase
    endfunction

endpackage

// File: rtl/exc_nmi_latch.sv
module exc_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_line,
    input  logic clear,
    output logic pending
);
    logic line_q;
    logic held_q;
    logic rise;

    assign rise    = nmi_line & ~line_q;
    assign pending = held_q | rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
            held_q <= 1'b0;
        end else begin
            line_q <= nmi_line;
            held_q <= pending & ~clear;
        end
    end
endmodule

// File: rtl/exc_step_ctr.sv
module exc_step_ctr #(
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [STEP_W-1:0] last_idx,
    output logic              busy,
    output logic [STEP_W-1:0] idx,
    output logic              final_step
);
    logic              busy_q;
    logic [STEP_W-1:0] idx_q;

    assign busy       = busy_q;
    assign idx        = idx_q;
    assign final_step = busy_q && (idx_q == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (launch) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (final_step) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (busy_q) begin
            idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/exc_step_exec.sv
module exc_step_exec
    import exc_seq_pkg::*;
#(
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input  op_e         op,
    input  ctx_t        ctx,
    input  logic [15:0] vec_base,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic        mem_re,
    output logic [7:0]  mem_wdata,
    output ctx_t        ctx_nx
);
    logic [7:0] sp_up;
    logic [7:0] sp_dn;

    assign sp_up = ctx.sp + 8'd1;
    assign sp_dn = ctx.sp - 8'd1;

    always_comb begin
        ctx_nx    = ctx;
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        case (op)
            OP_PUSH_HI: begin
                mem_we    = 1'b1;
                mem_addr  = {STACK_PAGE, ctx.sp};
                mem_wdata = ctx.pc[15:8];
                ctx_nx.sp = sp_dn;
            end
            OP_PUSH_LO: begin
                mem_we    = 1'b1;
                mem_addr  = {STACK_PAGE, ctx.sp};
                mem_wdata = ctx.pc[7:0];
                ctx_nx.sp = sp_dn;
            end
            OP_PUSH_ST: begin
                mem_we    = 1'b1;
                mem_addr  = {STACK_PAGE, ctx.sp};
                mem_wdata = ctx.st;
                ctx_nx.sp = sp_dn;
                ctx_nx.st = ctx.st | MASK_I;
            end
            OP_VEC_LO: begin
                mem_re         = 1'b1;
                mem_addr       = vec_base;
                ctx_nx.pc[7:0] = mem_rdata;
            end
            OP_VEC_HI: begin
                mem_re          = 1'b1;
                mem_addr        = vec_base + 16'd1;
                ctx_nx.pc[15:8] = mem_rdata;
            end
            OP_PULL_ST: begin
                mem_re    = 1'b1;
                mem_addr  = {STACK_PAGE, sp_up};
                ctx_nx.sp = sp_up;
                ctx_nx.st = mem_rdata | MASK_R;
            end
            OP_PULL_LO: begin
                mem_re         = 1'b1;
                mem_addr       = {STACK_PAGE, sp_up};
                ctx_nx.sp      = sp_up;
                ctx_nx.pc[7:0] = mem_rdata;
            end
            OP_PULL_HI: begin
                mem_re          = 1'b1;
                mem_addr        = {STACK_PAGE, sp_up};
                ctx_nx.sp       = sp_up;
                ctx_nx.pc[15:8] = mem_rdata;
            end
            default: begin
                ctx_nx = ctx;
            end
        endcase
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter logic [7:0]  STACK_PAGE  = 8'h01,
    parameter logic [15:0] NMI_VEC     = 16'hFFFA,
    parameter logic [15:0] IRQ_VEC     = 16'hFFFE,
    parameter int          BRK_ADVANCE = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        brk_go,
    input  logic        rti_go,
    input  logic        irq_req,
    input  logic        nmi_req,
    input  logic [15:0] cur_pc,
    input  logic [7:0]  cur_sp,
    input  logic [7:0]  cur_st,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic        mem_re,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] new_pc,
    output logic [7:0]  new_sp,
    output logic [7:0]  new_st
);
    src_e              pick;
    src_e              src_q;
    logic              launch;
    logic              nmi_pend;
    logic [STEP_W-1:0] idx;
    logic              final_step;
    logic              done_q;
    op_e               op;
    ctx_t              ctx_q;
    ctx_t              ctx_nx;
    logic [15:0]       vec_base;

    exc_nmi_latch u_nmi (
        .clk      (clk),
        .rst      (rst),
        .nmi_line (nmi_req),
        .clear    (pick == SRC_NMI),
        .pending  (nmi_pend)
    );

    always_comb begin
        pick = SRC_NONE;
        if (!busy) begin
            if (brk_go)                          pick = SRC_BRK;
            else if (rti_go)                     pick = SRC_RTI;
            else if (nmi_pend)                   pick = SRC_NMI;
            else if (irq_req && !cur_st[FLAG_I]) pick = SRC_IRQ;
        end
    end

    assign launch = (pick != SRC_NONE);

    exc_step_ctr #(.STEP_W(STEP_W)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .last_idx   (last_step(src_q)),
        .busy       (busy),
        .idx        (idx),
        .final_step (final_step)
    );

    assign op       = busy ? step_op(src_q, idx) : OP_WAIT;
    assign vec_base = (src_q == SRC_NMI) ? NMI_VEC : IRQ_VEC;

    exc_step_exec #(.STACK_PAGE(STACK_PAGE)) u_exec (
        .op        (op),
        .ctx       (ctx_q),
        .vec_base  (vec_base),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata),
        .ctx_nx    (ctx_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= SRC_NONE;
            ctx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= final_step;
            if (launch) begin
                src_q    <= pick;
                ctx_q.pc <= (pick == SRC_BRK) ? cur_pc + 16'(BRK_ADVANCE) : cur_pc;
                ctx_q.sp <= cur_sp;
                ctx_q.st <= entry_status(pick, cur_st);
            end else if (busy) begin
                ctx_q <= ctx_nx;
            end
        end
    end

    assign done   = done_q;
    assign new_pc = ctx_q.pc;
    assign new_sp = ctx_q.sp;
    assign new_st = ctx_q.st;
endmodule

// File: rtl/exc_seq_checker.sv
module exc_seq_checker
    import exc_seq_pkg::*;
#(
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        mem_we,
    input logic        mem_re,
    input logic [15:0] mem_addr,
    input logic        irq_mask,
    input logic        st_i,
    input logic        st_r,
    input src_e        src_q
);
    logic [3:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst) busy_run <= '0;
        else     busy_run <= busy ? busy_run + 4'd1 : 4'd0;
    end

    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_busy_length_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_run == ((src_q == SRC_RTI) ? 4'(RETURN_STEPS) : 4'(ENTRY_STEPS))));

    assert_push_in_page_R2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[15:8] == STACK_PAGE));

    assert_push_descends_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr[7:0] == $past(mem_addr[7:0]) - 8'd1));

    assert_port_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    assert_port_only_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> busy);

    assert_mask_after_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (done && src_q != SRC_RTI) |-> st_i);

    assert_bit5_after_return_R10: assert property (@(posedge clk) disable iff (rst)
        (done && src_q == SRC_RTI) |-> st_r);

    assert_irq_unmasked_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && src_q == SRC_IRQ) |-> !$past(irq_mask));
endmodule

bind exc_entry_seq exc_seq_checker #(.STACK_PAGE(STACK_PAGE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .irq_mask (cur_st[exc_seq_pkg::FLAG_I]),
    .st_i     (new_st[exc_seq_pkg::FLAG_I]),
    .st_r     (new_st[exc_seq_pkg::FLAG_R]),
    .src_q    (src_q)
);

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
    localparam int KB = 0;
    localparam int KI = 1;
    localparam int KN = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst, brk_go, rti_go, irq_req, nmi_req;
    logic [15:0] cur_pc;
    logic [7:0]  cur_sp, cur_st;
    logic [15:0] mem_addr, new_pc;
    logic        mem_we, mem_re, busy, done;
    logic [7:0]  mem_wdata, mem_rdata, new_sp, new_st;

    exc_entry_seq uut (
        .clk(clk), .rst(rst), .brk_go(brk_go), .rti_go(rti_go),
        .irq_req(irq_req), .nmi_req(nmi_req), .cur_pc(cur_pc), .cur_sp(cur_sp),
        .cur_st(cur_st), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .new_pc(new_pc), .new_sp(new_sp), .new_st(new_st)
    );

    // behavioural memory: stack page plus four vector bytes
    logic [7:0] stk [256];
    logic       pre_we;
    logic [7:0] pre_a, pre_d;

    always @(posedge clk) begin
        if (mem_we) stk[mem_addr[7:0]] <= mem_wdata;
        else if (pre_we) stk[pre_a] <= pre_d;
    end

    always_comb begin
        if (mem_addr[15:8] == 8'h01) mem_rdata = stk[mem_addr[7:0]];
        else begin
            case (mem_addr)
                16'hFFFA: mem_rdata = 8'h34;
                16'hFFFB: mem_rdata = 8'h12;
                16'hFFFE: mem_rdata = 8'h78;
                16'hFFFF: mem_rdata = 8'h56;
                default:  mem_rdata = 8'hEE;
            endcase
        end
    end

    typedef struct {
        bit          busy, done, we, re, chk;
        logic [15:0] addr, pc;
        logic [7:0]  wd, sp, st;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   live = 0;

    function automatic exp_t mk(bit b, bit d, bit w, bit r, logic [15:0] a, logic [7:0] wd, string tag);
        exp_t e;
        e.busy = b; e.done = d; e.we = w; e.re = r; e.addr = a; e.wd = wd;
        e.chk = 0; e.pc = '0; e.sp = '0; e.st = '0; e.tag = tag;
        return e;
    endfunction

    function automatic void q_entry(int kind, logic [15:0] pc, logic [7:0] sp, logic [7:0] st, string why);
        logic [15:0] rpc, vec, npc;
        logic [7:0]  pst;
        exp_t        e;
        rpc = (kind == KB) ? pc + 16'd2 : pc;
        pst = (kind == KB) ? (st | 8'h10) : (st & 8'hEF);
        vec = (kind == KN) ? 16'hFFFA : 16'hFFFE;
        npc = (kind == KN) ? 16'h1234 : 16'h5678;
        q.push_back(mk(1, 0, 0, 0, 16'h0, 8'h0, {why, " R6 internal cycle"}));
        q.push_back(mk(1, 0, 0, 0, 16'h0, 8'h0, {why, " R6 internal cycle"}));
        q.push_back(mk(1, 0, 1, 0, {8'h01, sp}, rpc[15:8], {why, " R2 R3 push pc high"}));
        q.push_back(mk(1, 0, 1, 0, {8'h01, 8'(sp - 8'd1)}, rpc[7:0], {why, " R2 R3 push pc low"}));
        q.push_back(mk(1, 0, 1, 0, {8'h01, 8'(sp - 8'd2)}, pst, {why, " R2 R3 push status"}));
        q.push_back(mk(1, 0, 0, 1, vec, 8'h0, {why, " R5 R11 vector low"}));
        q.push_back(mk(1, 0, 0, 1, vec + 16'd1, 8'h0, {why, " R5 R11 vector high"}));
        e = mk(0, 1, 0, 0, 16'h0, 8'h0, {why, " R4 R5 R6 entry done"});
        e.chk = 1; e.pc = npc; e.sp = sp - 8'd3; e.st = pst | 8'h04;
        q.push_back(e);
    endfunction

    function automatic void q_return(logic [7:0] sp, logic [15:0] pc, logic [7:0] st, string why);
        exp_t e;
        for (int i = 0; i < 3; i++) q.push_back(mk(1, 0, 0, 0, 16'h0, 8'h0, {why, " R6 internal cycle"}));
        q.push_back(mk(1, 0, 0, 1, {8'h01, 8'(sp + 8'd1)}, 8'h0, {why, " R10 pull status"}));
        q.push_back(mk(1, 0, 0, 1, {8'h01, 8'(sp + 8'd2)}, 8'h0, {why, " R10 pull pc low"}));
        q.push_back(mk(1, 0, 0, 1, {8'h01, 8'(sp + 8'd3)}, 8'h0, {why, " R10 pull pc high"}));
        e = mk(0, 1, 0, 0, 16'h0, 8'h0, {why, " R6 R10 return done"});
        e.chk = 1; e.pc = pc; e.sp = sp + 8'd3; e.st = st | 8'h20;
        q.push_back(e);
    endfunction

    // cycle-by-cycle comparison against the expected queue
    always @(negedge clk) begin
        if (live) begin
            exp_t e;
            if (q.size() > 0) e = q.pop_front();
            else e = mk(0, 0, 0, 0, 16'h0, 8'h0, "R7 R9 idle port");
            total++;
            if (busy !== e.busy || done !== e.done || mem_we !== e.we || mem_re !== e.re ||
                ((e.we || e.re) && mem_addr !== e.addr) || (e.we && mem_wdata !== e.wd)) begin
                bad++;
                $display("FAIL %s: got busy=%0b done=%0b we=%0b re=%0b addr=%h wd=%h expected busy=%0b done=%0b we=%0b re=%0b addr=%h wd=%h",
                         e.tag, busy, done, mem_we, mem_re, mem_addr, mem_wdata,
                         e.busy, e.done, e.we, e.re, e.addr, e.wd);
            end
            if (e.chk) begin
                total++;
                if (new_pc !== e.pc || new_sp !== e.sp || new_st !== e.st) begin
                    bad++;
                    $display("FAIL %s: got pc=%h sp=%h st=%h expected pc=%h sp=%h st=%h",
                             e.tag, new_pc, new_sp, new_st, e.pc, e.sp, e.st);
                end
            end
        end
    end

    task automatic drive(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] st);
        cur_pc = pc; cur_sp = sp; cur_st = st;
    endtask

    task automatic wait_idle();
        wait (q.size() == 0);
        @(posedge clk); #1;
    endtask

    task automatic preset(input logic [7:0] a, input logic [7:0] d);
        pre_a = a; pre_d = d; pre_we = 1'b1;
        @(posedge clk); #1;
        pre_we = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        rst = 1; brk_go = 0; rti_go = 0; irq_req = 0; nmi_req = 0; pre_we = 0;
        pre_a = 0; pre_d = 0;
        drive(16'h0, 8'h0, 8'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (busy !== 0 || done !== 0 || mem_we !== 0 || mem_re !== 0 ||
            new_pc !== 0 || new_sp !== 0 || new_st !== 0) begin
            bad++;
            $display("FAIL R1 reset: got busy=%0b done=%0b we=%0b re=%0b pc=%h sp=%h st=%h expected all zero",
                     busy, done, mem_we, mem_re, new_pc, new_sp, new_st);
        end
        @(posedge clk); #1;
        rst = 0; live = 1;
        @(posedge clk); #1;

        // R3 break: pushes pc+2 and status with bit 4 set
        drive(16'h1000, 8'hFD, 8'h21);
        brk_go = 1;
        @(posedge clk); #1;
        brk_go = 0;
        q_entry(KB, 16'h1000, 8'hFD, 8'h21, "R3 break");
        wait_idle();

        // R10 return from the frame just pushed
        drive(16'h0, 8'hFA, 8'h00);
        rti_go = 1;
        @(posedge clk); #1;
        rti_go = 0;
        q_return(8'hFA, 16'h1002, 8'h31, "R10 round trip");
        wait_idle();

        // R10 return with bit 5 clear in memory and wrap across the page end
        preset(8'hFF, 8'hC3);
        preset(8'h00, 8'hCD);
        preset(8'h01, 8'hAB);
        drive(16'h0, 8'hFE, 8'h00);
        rti_go = 1;
        @(posedge clk); #1;
        rti_go = 0;
        q_return(8'hFE, 16'hABCD, 8'hC3, "R10 wrap");
        wait_idle();

        // R7 maskable entry, B clear in pushed status, R2 stack wrap
        drive(16'h2345, 8'h01, 8'h90);
        irq_req = 1;
        @(posedge clk); #1;
        irq_req = 0;
        q_entry(KI, 16'h2345, 8'h01, 8'h90, "R7 irq");
        wait_idle();

        // R7 masked request leaves the port idle
        drive(16'h2345, 8'h80, 8'h04);
        irq_req = 1;
        repeat (6) @(posedge clk);
        #1 irq_req = 0;
        @(posedge clk); #1;

        // R8 non-maskable entry, then level held high must not retrigger
        drive(16'h4000, 8'h80, 8'h00);
        nmi_req = 1;
        @(posedge clk); #1;
        q_entry(KN, 16'h4000, 8'h80, 8'h00, "R8 nmi");
        wait_idle();
        repeat (8) @(posedge clk);
        #1 nmi_req = 0;
        @(posedge clk); #1;

        // R8 edge during a break is latched and served right after
        drive(16'h3000, 8'h40, 8'h00);
        brk_go = 1;
        @(posedge clk); #1;
        brk_go = 0;
        q_entry(KB, 16'h3000, 8'h40, 8'h00, "R8 break then latched nmi");
        q_entry(KN, 16'h3000, 8'h40, 8'h00, "R8 latched nmi");
        repeat (2) @(posedge clk);
        #1 nmi_req = 1;
        @(posedge clk); #1;
        nmi_req = 0;
        wait_idle();

        // R9 priority: break, then nmi, then irq, all raised together
        drive(16'h5000, 8'hF0, 8'h00);
        brk_go = 1; irq_req = 1; nmi_req = 1;
        @(posedge clk); #1;
        brk_go = 0;
        q_entry(KB, 16'h5000, 8'hF0, 8'h00, "R9 first break");
        q_entry(KN, 16'h5000, 8'hF0, 8'h00, "R9 second nmi");
        q_entry(KI, 16'h5000, 8'hF0, 8'h00, "R9 third irq");
        wait (q.size() <= 5);
        #1 irq_req = 0;
        wait_idle();
        nmi_req = 0;
        @(posedge clk); #1;

        // R9 strobes during busy are ignored
        drive(16'h6000, 8'h20, 8'h00);
        brk_go = 1;
        @(posedge clk); #1;
        brk_go = 0;
        q_entry(KB, 16'h6000, 8'h20, 8'h00, "R9 busy strobes");
        repeat (2) @(posedge clk);
        #1 begin brk_go = 1; rti_go = 1; end
        @(posedge clk); #1;
        brk_go = 0; rti_go = 0;
        wait_idle();
        repeat (4) @(posedge clk);
        #1 live = 0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule